// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block walks through the column addresses of one SDRAM read or write burst. A column command starts it by pulsing `start_i` together with a start column, a burst-length code and an ordering select. From the following cycle on it presents one column per rising clock edge. `beat_vld_o` marks each address and `last_o` flags the closing beat. A controller places each address on the column lines and moves data in step with it.

The fixed lengths are 1, 2, 4 and 8 beats. For these lengths the low address bits wrap inside an aligned block, in either a counting order or an XOR order. The upper bits keep the value of the start column. In page mode the block steps through the whole row, wrapping modulo the page size (2^COL_W, default 256). It never ends the burst by itself. A new `start_i` cuts any burst short and begins a fresh one, which allows random column access. `stop_i` ends a burst without starting another.

The output side has no back-pressure. Each beat is shown for exactly one cycle, so the consumer must accept an address in every cycle in which `beat_vld_o` is high. `COL_W` must be at least 3.

Top module: `sdram_col_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `beat_vld_o` and `last_o` are 0.
- R2: A cycle with `start_i`=1 at a rising edge is followed by beat 0: `beat_vld_o`=1 and `col_o` equal to the sampled `start_col_i`.
- R3: `len_i` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats, on consecutive cycles. `beat_vld_o` drops in the cycle after the last beat unless a new start arrived.
- R4: With `order_i`=0 (sequential) and a fixed length BL, the low log2(BL) bits of beat n are (start low bits + n) mod BL. The upper bits equal those of the start column.
- R5: With `order_i`=1 (interleave) and a fixed length, the low log2(BL) bits of beat n are the start column's low bits XOR n. The upper bits are unchanged.
- R6: `len_i` codes 4 to 7 select page mode. Beat n is (start column + n) mod 2^COL_W, `order_i` is ignored, and the burst continues until `start_i` or `stop_i` ends it.
- R7: `last_o` is 1 only on the final beat of a fixed-length burst. With length 1 it is set on beat 0. It is never set in page mode.
- R8: `start_i` during a running burst restarts it on the next cycle with the newly sampled column, length and order. `start_i` wins over `stop_i` in the same cycle.
- R9: `stop_i`=1 without `start_i` makes `beat_vld_o` 0 from the next cycle until the next start.
- R10: Changes to `start_col_i`, `len_i` and `order_i` while `start_i` is 0 have no effect on a burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Column command: begin a new burst |
| stop_i | input | 1 | End the current burst without a new one |
| start_col_i | input | COL_W | First column of the burst |
| len_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 4..7 give page mode |
| order_i | input | 1 | 0 sequential wrap, 1 interleaved wrap |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | Column address valid this cycle |
| last_o | output | 1 | Current beat closes the burst |

## Verification
Every start column is run through every fixed length in both orderings. An exhaustive sweep is the only way to separate a wrap that stays inside its aligned block from one that carries into the upper bits, and to separate the XOR order from the counting order: the two agree whenever the start's low bits are zero. Page-mode bursts start near the top of the row and use both order settings. This exposes a missing wrap at 2^COL_W, a spurious last beat, or a leak of the interleave select. Restarts in mid-burst, a start and a stop in the same cycle, and changes to the held inputs during a burst show whether the command is sampled only on its strobe and whether start takes priority.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } col_order_e;

  localparam int LEN_CODE_W = 3;

  // Codes with the top bit set select page mode.
  function automatic logic len_is_page(input logic [LEN_CODE_W-1:0] code);
    return code[LEN_CODE_W-1];
  endfunction
endpackage

// File: rtl/sdram_col_beat_ctrl.sv
module sdram_col_beat_ctrl
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_i,
  input  logic                  order_i,
  output logic                  active_o,
  output logic [COL_W-1:0]      beat_o,
  output logic [COL_W-1:0]      base_o,
  output logic [LEN_CODE_W-1:0] code_o,
  output col_order_e            ord_o,
  output logic                  last_o
);
  logic                  active_q;
  logic [COL_W-1:0]      beat_q;
  logic [COL_W-1:0]      base_q;
  logic [LEN_CODE_W-1:0] code_q;
  col_order_e            ord_q;
  logic [COL_W-1:0]      final_beat;
  logic                  at_end;

  // final beat index = BL-1: the low code bits give the count of ones
  for (genvar g = 0; g < COL_W; g++) begin : g_final
    if (g < 3) begin : g_low
      assign final_beat[g] = (code_q[1:0] > 2'(g));
    end else begin : g_high
      assign final_beat[g] = 1'b0;
    end
  end

  assign at_end = active_q && !len_is_page(code_q) && (beat_q == final_beat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      code_q   <= '0;
      ord_q    <= ORD_SEQ;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col_i;
      code_q   <= len_i;
      ord_q    <= col_order_e'(order_i);
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (at_end) active_q <= 1'b0;
      else        beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign code_o   = code_q;
  assign ord_o    = ord_q;
  assign last_o   = at_end;
endmodule

// File: rtl/sdram_col_order_map.sv
module sdram_col_order_map
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0]      base_i,
  input  logic [COL_W-1:0]      beat_i,
  input  logic [LEN_CODE_W-1:0] code_i,
  input  col_order_e            ord_i,
  output logic [COL_W-1:0]      col_o
);
  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    if (g < 3) begin : g_low
      assign wrap_mask[g] = (code_i[1:0] > 2'(g));
    end else begin : g_high
      assign wrap_mask[g] = 1'b0;
    end
  end

  assign sum     = base_i + beat_i;
  assign seq_col = (base_i & ~wrap_mask) | (sum & wrap_mask);
  assign ilv_col = base_i ^ (beat_i & wrap_mask);

  always_comb begin
    if (len_is_page(code_i))  col_o = sum;
    else if (ord_i == ORD_ILV) col_o = ilv_col;
    else                       col_o = seq_col;
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_i,
  input  logic             order_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             last_o
);
  logic                  active;
  logic [COL_W-1:0]      beat;
  logic [COL_W-1:0]      base;
  logic [LEN_CODE_W-1:0] code;
  col_order_e            ord;

  sdram_col_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .len_i       (len_i),
    .order_i     (order_i),
    .active_o    (active),
    .beat_o      (beat),
    .base_o      (base),
    .code_o      (code),
    .ord_o       (ord),
    .last_o      (last_o)
  );

  sdram_col_order_map #(.COL_W(COL_W)) u_map (
    .base_i (base),
    .beat_i (beat),
    .code_i (code),
    .ord_i  (ord),
    .col_o  (col_o)
  );

  assign beat_vld_o = active;
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             last_o
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_vld_o); // R7
  AST_START_GIVES_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (beat_vld_o && col_o == $past(start_col_i))); // R2
  AST_BL1_LAST_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_i == 3'd0) |=> last_o); // R7
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_i[2]) |=> !last_o); // R6
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !beat_vld_o); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !beat_vld_o); // R3
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .start_col_i (start_col_i),
  .len_i       (len_i),
  .col_o       (col_o),
  .beat_vld_o  (beat_vld_o),
  .last_o      (last_o)
);

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb;
  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_i = '0;
  logic             order_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             beat_vld_o;
  logic             last_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag = "R1";

  // reference state
  bit ref_act = 0;
  int ref_n = 0, ref_base = 0, ref_code = 0, ref_ord = 0;

  always #2.5 clk = ~clk;

  sdram_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .start_col_i(start_col_i), .len_i(len_i), .order_i(order_i),
    .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
  );

  function automatic int ref_len(input int code);
    return (code >= 4) ? 0 : (1 << code);
  endfunction

  function automatic bit ref_is_last();
    return ref_act && ref_code < 4 && ref_n == ref_len(ref_code) - 1;
  endfunction

  function automatic int ref_col();
    int bl, blk, off;
    if (ref_code >= 4) return (ref_base + ref_n) % PAGE;
    bl  = ref_len(ref_code);
    off = ref_base % bl;
    blk = ref_base - off;
    if (ref_ord == 1) return blk + (off ^ ref_n);
    return blk + ((off + ref_n) % bl);
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL R3 watchdog: cycles=%0d expected below %0d", cycles, 150000);
      summary();
    end
    if (!rst_n) begin
      ref_act = 0;
    end else if (start_i) begin
      ref_act = 1; ref_n = 0; ref_base = start_col_i;
      ref_code = len_i; ref_ord = order_i;
    end else if (stop_i) begin
      ref_act = 0;
    end else if (ref_act) begin
      if (ref_is_last()) ref_act = 0;
      else ref_n = (ref_n + 1) % PAGE;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_col;
      bit ok;
      exp_col = ref_act ? ref_col() : 0;
      ok = (beat_vld_o == ref_act) && (last_o == ref_is_last()) &&
           (!ref_act || int'(col_o) == exp_col);
      checks++;
      if (!ok) begin
        failures++;
        $display("FAIL %s: vld=%0d last=%0d col=%0d expected vld=%0d last=%0d col=%0d",
                 tag, beat_vld_o, last_o, col_o, ref_act, ref_is_last(), exp_col);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick(input int col, input int code, input int ord);
    @(negedge clk);
    start_i = 1'b1; start_col_i = COL_W'(col); len_i = 3'(code); order_i = ord[0];
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    // R1: reset state
    idle(3);
    checks++;
    if (beat_vld_o !== 1'b0 || last_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: vld=%0d last=%0d expected 0 0", beat_vld_o, last_o);
    end
    rst_n = 1'b1;
    idle(2);

    // R4, R5, R3, R7, R2: exhaustive fixed-length sweep
    for (int ord = 0; ord < 2; ord++)
      for (int code = 0; code < 4; code++)
        for (int c = 0; c < PAGE; c++) begin
          tag = (ord == 0) ? "R4/R3/R7/R2" : "R5/R3/R7/R2";
          kick(c, code, ord);
          idle(1 << code);
        end

    // R6: page mode wraps, order ignored, then R9 stop
    for (int ord = 0; ord < 2; ord++) begin
      tag = "R6";
      kick(250, 4 + ord * 3, ord);
      idle(270);
      tag = "R9";
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      idle(4);
    end

    // R8: restart in mid-burst, and start plus stop together
    tag = "R8";
    kick(5, 3, 0);
    idle(2);
    kick(42, 2, 1);
    idle(1);
    @(negedge clk);
    start_i = 1'b1; stop_i = 1'b1; start_col_i = 8'd77; len_i = 3'd3; order_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    idle(10);

    // R10: held inputs wiggle during a burst
    tag = "R10";
    kick(13, 3, 1);
    for (int i = 0; i < 7; i++) begin
      start_col_i = COL_W'(i * 37); len_i = 3'(i); order_i = ~order_i;
      @(negedge clk);
    end
    idle(3);
    tag = "R10/R6";
    kick(3, 5, 0);
    for (int i = 0; i < 20; i++) begin
      start_col_i = COL_W'(i * 11); len_i = 3'(i % 4); order_i = i[0];
      @(negedge clk);
    end
    tag = "R9";
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    idle(5);

    summary();
  end
endmodule